// File: doc/BRIEF.md
# Two-Channel Prescaled PWM Generator

This block is a small register-mapped pulse-width modulator with two independent outputs. Software reaches it over a plain 32-bit bus with a request, a write strobe and a byte address. One shared control word holds a ten-bit settings field for each channel. Each channel also has its own word that holds a period value and a duty value. Each channel divides the input clock by a selectable ratio and counts from zero up to its programmed period value, then starts again. The output sits at its active level while the count is below the duty value.

New period and duty values do not reach the counter straight away. A write is first held in a shadow copy, and a per-channel busy flag reads high while that copy waits. The copy is moved into the live registers when the running period wraps, or on the next clock if the channel is stopped. While a channel's busy flag is high, further writes to that channel's period word are dropped. The mode, single-pulse and bypass bits of each settings field are stored and read back, but they have no effect on the output.

Top module: `pwm2_ctrl`

## Requirements
- R1: The control word is at byte address 0x0. Channel n's period/duty word is at 0x4 + 4·n. A read of any other word address (0xC) returns zero.
- R2: Channel n's settings field starts at bit 15·n of the control word. Inside the field, bits [3:0] select the divider, bit 4 is enable, bit 5 is the active level, bit 6 is the clock gate, and bits 7, 8 and 9 are stored mode, single-pulse and bypass bits. Only bits [9:0] and [24:15] are writable. Every other bit reads 0, except the busy flags.
- R3: Divider codes 0, 1, 2, 3 and 4 advance the counter once every 120, 180, 240, 360 and 480 clocks. Codes 8, 9, 10, 11 and 12 advance it once every 12000, 24000, 36000, 48000 and 72000 clocks.
- R4: Divider code 15 advances the counter on every clock.
- R5: Divider codes 5, 6, 7, 13 and 14 freeze the counter, so the output holds its level.
- R6: Bits [31:16] of a period word hold P (the period length minus one) and bits [15:0] hold the duty D. One period lasts (P+1)·N clocks, and the output is active while the count is below D.
- R7: D = 0 gives a constant inactive output. D > P gives a constant active output.
- R8: With the active-level bit at 1, the active level is high. With it at 0, the active level is low and the inactive level is high.
- R9: A channel runs only while both its enable bit and its clock-gate bit are 1. Otherwise its counter is held at zero and its output sits at the inactive level.
- R10: A write to a period word while its channel is not busy goes to the shadow copy and sets the busy flag (bit 28 + n of the control word). The value read back from the period word stays unchanged until the load.
- R11: The shadow copy loads, and busy clears, on the clock where a running channel's count wraps from P to 0. On a stopped channel this happens on the next clock.
- R12: A write to a period word while its channel is busy is ignored. Writes to the busy bits have no effect.
- R13: After reset, every register, counter and busy flag is zero, so both outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data; combinational, zero unless a read is requested |
| pwm_o | output | N_CH | Channel outputs |

## Verification
The hardest situation to reach is a second write that lands while the first is still waiting. The channel runs with a divide-by-120 ratio, so one period lasts hundreds of clocks. The bench writes a value, writes a different one a few clocks later, and reads the word back before and after the wrap. Only the first value may appear, and only after the wrap. The slow divider ratios are checked by counting active samples over whole periods, while a behavioural model of the counters follows every clock.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;

  localparam int unsigned RATIO_W = 17;
  localparam logic [3:0]  PSC_DIRECT = 4'hF;

  typedef struct packed {
    logic       bypass;
    logic       pulse;
    logic       mode;
    logic       gate;
    logic       act;
    logic       en;
    logic [3:0] psc;
  } chan_cfg_t;

  localparam int unsigned CFG_W = $bits(chan_cfg_t);

  // clocks per count step; 0 marks an unused code
  function automatic logic [RATIO_W-1:0] psc_ratio(input logic [3:0] code);
    case (code)
      4'd0:    return RATIO_W'(120);
      4'd1:    return RATIO_W'(180);
      4'd2:    return RATIO_W'(240);
      4'd3:    return RATIO_W'(360);
      4'd4:    return RATIO_W'(480);
      4'd8:    return RATIO_W'(12000);
      4'd9:    return RATIO_W'(24000);
      4'd10:   return RATIO_W'(36000);
      4'd11:   return RATIO_W'(48000);
      4'd12:   return RATIO_W'(72000);
      4'd15:   return RATIO_W'(1);
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/pwm2_prescaler.sv
module pwm2_prescaler
  import pwm2_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [3:0] code_i,
  output logic       tick_o
);

  logic [RATIO_W-1:0] ratio;
  logic [RATIO_W-1:0] div_q;
  logic               direct;
  logic               valid;

  assign ratio  = psc_ratio(code_i);
  assign direct = (code_i == PSC_DIRECT);
  assign valid  = (ratio != '0);
  assign tick_o = run_i && (direct || (valid && (div_q >= ratio - 1'b1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               div_q <= '0;
    else if (!run_i || direct) div_q <= '0;
    else if (!valid)           div_q <= div_q;
    else if (tick_o)           div_q <= '0;
    else                       div_q <= div_q + 1'b1;
  end

  // a divided tick is never followed at once by another unless bypass is chosen
  p_tick_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !direct) ##1 !direct |-> !tick_o);

  p_direct_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && direct) |=> (div_q == '0));

endmodule

// File: rtl/pwm2_channel.sv
module pwm2_channel
  import pwm2_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  chan_cfg_t          cfg_i,
  input  logic               tick_i,
  input  logic               wr_i,
  input  logic [2*CNT_W-1:0] wdata_i,
  output logic               busy_o,
  output logic [CNT_W-1:0]   prd_o,
  output logic [CNT_W-1:0]   dty_o,
  output logic               pwm_o
);

  localparam int unsigned WORD_W = 2 * CNT_W;

  logic              run, wrap, load, hit;
  logic [CNT_W-1:0]  cnt_q, prd_q, dty_q;
  logic [WORD_W-1:0] sh_q;
  logic              busy_q;
  logic              unused_cfg;

  assign unused_cfg = ^{cfg_i.mode, cfg_i.pulse, cfg_i.bypass};

  assign run  = cfg_i.en & cfg_i.gate;
  assign wrap = tick_i && (cnt_q >= prd_q);
  assign load = busy_q && (!run || wrap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick_i) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      busy_q <= 1'b0;
    end else if (wr_i && !busy_q) begin
      sh_q   <= wdata_i;
      busy_q <= 1'b1;
    end else if (load) begin
      busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prd_q <= '0;
      dty_q <= '0;
    end else if (load) begin
      prd_q <= sh_q[WORD_W-1:CNT_W];
      dty_q <= sh_q[CNT_W-1:0];
    end
  end

  assign hit    = run && (cnt_q < dty_q);
  assign pwm_o  = cfg_i.act ? hit : ~hit;
  assign busy_o = busy_q;
  assign prd_o  = prd_q;
  assign dty_o  = dty_q;

  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |-> (cnt_q <= prd_q));

  p_unused_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && psc_ratio(cfg_i.psc) == '0) |=> $stable(cnt_q));

  p_stop_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> (cnt_q == '0));

  p_busy_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !busy_q) |=> busy_q);

  p_live_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && run && !tick_i) |=> ($stable(prd_q) && $stable(dty_q) && busy_q));

  p_idle_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !run) |=> !busy_q);

  p_wr_blocked_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && busy_q) |=> $stable(sh_q));

endmodule

// File: rtl/pwm2_ctrl.sv
module pwm2_ctrl
  import pwm2_pkg::*;
#(
  parameter int unsigned N_CH   = 2,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic [N_CH-1:0]   pwm_o
);

  localparam int unsigned IDX_W     = ADDR_W - 2;
  localparam int unsigned STRIDE    = 15;
  localparam int unsigned BUSY_BASE = 28;

  chan_cfg_t [N_CH-1:0]            cfg_q;
  logic [N_CH-1:0]                 run, tick, busy, wr_prd;
  logic [N_CH-1:0][CNT_W-1:0]      prd, dty;
  logic [IDX_W-1:0]                idx;
  logic                            ctrl_wr, rd_en;
  logic                            unused_addr;

  assign idx         = bus_addr_i[ADDR_W-1:2];
  assign unused_addr = ^bus_addr_i[1:0];
  assign ctrl_wr     = bus_req_i && bus_we_i && (idx == '0);
  assign rd_en       = bus_req_i && !bus_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (ctrl_wr) begin
      for (int c = 0; c < N_CH; c++)
        cfg_q[c] <= chan_cfg_t'(bus_wdata_i[STRIDE*c +: CFG_W]);
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (rd_en) begin
      if (idx == '0) begin
        for (int c = 0; c < N_CH; c++) begin
          bus_rdata_o[STRIDE*c +: CFG_W] = cfg_q[c];
          bus_rdata_o[BUSY_BASE + c]     = busy[c];
        end
      end else begin
        for (int c = 0; c < N_CH; c++)
          if (idx == IDX_W'(c + 1)) bus_rdata_o = {prd[c], dty[c]};
      end
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign run[c]    = cfg_q[c].en & cfg_q[c].gate;
    assign wr_prd[c] = bus_req_i && bus_we_i && (idx == IDX_W'(c + 1));

    pwm2_prescaler u_psc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run[c]),
      .code_i (cfg_q[c].psc),
      .tick_o (tick[c])
    );

    pwm2_channel #(.CNT_W(CNT_W)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cfg_i   (cfg_q[c]),
      .tick_i  (tick[c]),
      .wr_i    (wr_prd[c]),
      .wdata_i (bus_wdata_i),
      .busy_o  (busy[c]),
      .prd_o   (prd[c]),
      .dty_o   (dty[c]),
      .pwm_o   (pwm_o[c])
    );
  end

  p_cfg_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr |=> $stable(cfg_q));

  p_cfg_take_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> (cfg_q[0] == chan_cfg_t'($past(bus_wdata_i[CFG_W-1:0]))));

endmodule

// File: tb/pwm2_ctrl_tb.sv
`timescale 1ns/1ps
module pwm2_ctrl_tb;

  localparam int EN = 16, ACT = 32, GATE = 64;
  localparam logic [31:0] CTRL_MASK = 32'h01FF83FF;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  pwm;

  int  total = 0, bad = 0;
  bit  done = 0;

  // behavioural model state
  logic [31:0] m_ctrl = '0;
  int m_div[2] = '{0, 0};
  int m_cnt[2] = '{0, 0};
  int m_prd[2] = '{0, 0};
  int m_dty[2] = '{0, 0};
  logic [31:0] m_sh[2] = '{32'h0, 32'h0};
  bit m_busy[2] = '{0, 0};
  logic [31:0] ctrl_sw = '0;

  pwm2_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pwm_o(pwm)
  );

  always #2.5 clk = ~clk;

  function automatic int ratio(input int code);
    case (code)
      0: return 120;    1: return 180;    2: return 240;   3: return 360;  4: return 480;
      8: return 12000;  9: return 24000;  10: return 36000; 11: return 48000;
      12: return 72000; 15: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [9:0] fld(input int c);
    return 10'((m_ctrl >> (15 * c)) & 32'h3FF);
  endfunction

  function automatic logic exp_pwm(input int c);
    logic [9:0] f;
    logic h;
    f = fld(c);
    h = f[4] && f[6] && (m_cnt[c] < m_dty[c]);
    return f[5] ? h : !h;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [3:0] a);
    case (a[3:2])
      2'd0: return m_ctrl | (32'(m_busy[0]) << 28) | (32'(m_busy[1]) << 29);
      2'd1: return {16'(m_prd[0]), 16'(m_dty[0])};
      2'd2: return {16'(m_prd[1]), 16'(m_dty[1])};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ctrl = '0;
      for (int c = 0; c < 2; c++) begin
        m_div[c] = 0; m_cnt[c] = 0; m_prd[c] = 0; m_dty[c] = 0; m_sh[c] = '0; m_busy[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        logic [9:0] f;
        bit run, tick, wrap, load, wr;
        int n, code;
        f = fld(c);
        run = f[4] && f[6];
        code = int'(f[3:0]);
        n = ratio(code);
        tick = run && (code == 15 || (n != 0 && m_div[c] >= n - 1));
        wrap = tick && (m_cnt[c] >= m_prd[c]);
        load = m_busy[c] && (!run || wrap);
        wr = req && we && (int'(addr[3:2]) == c + 1);
        if (!run || code == 15) m_div[c] = 0;
        else if (n == 0) m_div[c] = m_div[c];
        else if (tick) m_div[c] = 0;
        else m_div[c] = m_div[c] + 1;
        if (!run) m_cnt[c] = 0;
        else if (tick) m_cnt[c] = wrap ? 0 : m_cnt[c] + 1;
        if (load) begin
          m_prd[c] = int'(m_sh[c][31:16]);
          m_dty[c] = int'(m_sh[c][15:0]);
        end
        if (wr && !m_busy[c]) begin
          m_sh[c] = wdata; m_busy[c] = 1;
        end else if (load) m_busy[c] = 0;
      end
      if (req && we && addr[3:2] == 2'd0) m_ctrl = wdata & CTRL_MASK;
    end
  end

  // clock-by-clock comparison against the model
  always @(negedge clk) begin
    if (rst_ni) begin
      #2;
      for (int c = 0; c < 2; c++) begin
        total++;
        if (pwm[c] !== exp_pwm(c)) begin
          bad++;
          $display("FAIL R6 ch%0d pwm act=%b exp=%b t=%0t", c, pwm[c], exp_pwm(c), $time);
        end
      end
      if (req && !we) begin
        total++;
        if (rdata !== exp_rd(addr)) begin
          bad++;
          $display("FAIL R10 read addr=%h act=%h exp=%h t=%0t", addr, rdata, exp_rd(addr), $time);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1;
    d = rdata;
  endtask

  task automatic set_ch(input int c, input int cfg);
    ctrl_sw = (ctrl_sw & ~(32'h3FF << (15 * c))) | ((32'(cfg) & 32'h3FF) << (15 * c));
    wr(4'h0, ctrl_sw);
  endtask

  task automatic count_high(input int ch, input int n, output int hi);
    hi = 0;
    repeat (n) begin
      #1;
      hi += int'(pwm[ch]);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int hi;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R13 reset state, R8 inactive level high with active bit 0
    rd(4'h0, d); chk("R13 ctrl", d, 32'h0);
    rd(4'h4, d); chk("R13 ch0 word", d, 32'h0);
    @(negedge clk);
    rd(4'h8, d); chk("R13 ch1 word", d, 32'h0);
    chk("R13 R8 outputs idle high", 32'(pwm), 32'h3);
    rd(4'hC, d); chk("R1 unmapped read", d, 32'h0);

    // R10/R11 stopped channel loads on next clock
    wr(4'h4, 32'h0003_0002);
    rd(4'h0, d); chk("R10 busy set", 32'(d[28]), 32'h1);
    rd(4'h4, d); chk("R10 live unchanged", d, 32'h0);
    @(negedge clk);
    rd(4'h0, d); chk("R11 busy cleared", 32'(d[28]), 32'h0);
    rd(4'h4, d); chk("R11 loaded", d, 32'h0003_0002);

    // R4 direct code, R6 duty 2 of 4
    set_ch(0, EN | ACT | GATE | 15);
    count_high(0, 16, hi); chk("R4 R6 direct duty", 32'(hi), 32'd8);

    // R3 divided codes on channel 1 (R2 field at bit 15)
    wr(4'h8, 32'h0001_0001);
    set_ch(1, EN | ACT | GATE | 0);
    count_high(1, 480, hi); chk("R3 div120", 32'(hi), 32'd240);
    set_ch(1, 0); set_ch(1, EN | ACT | GATE | 2);
    count_high(1, 960, hi); chk("R3 div240", 32'(hi), 32'd480);
    set_ch(1, 0); set_ch(1, EN | ACT | GATE | 4);
    count_high(1, 1920, hi); chk("R3 div480", 32'(hi), 32'd960);
    set_ch(1, 0); set_ch(1, EN | ACT | GATE | 9);
    count_high(1, 48000, hi); chk("R3 div24000", 32'(hi), 32'd24000);

    // R5 unused codes freeze the count at 0 (<duty 1) so output stays active
    set_ch(1, 0); set_ch(1, EN | ACT | GATE | 5);
    count_high(1, 100, hi); chk("R5 code5 frozen", 32'(hi), 32'd100);
    set_ch(1, 0); set_ch(1, EN | ACT | GATE | 13);
    count_high(1, 100, hi); chk("R5 code13 frozen", 32'(hi), 32'd100);
    set_ch(1, 0);

    // R10 R11 R12 on a slow running channel
    set_ch(0, 0); set_ch(0, EN | ACT | GATE | 0);
    wr(4'h4, 32'h0001_0001);
    wr(4'h4, 32'h0002_0000);
    rd(4'h4, d); chk("R10 live held while pending", d, 32'h0003_0002);
    rd(4'h0, d); chk("R10 busy while running", 32'(d[28]), 32'h1);
    repeat (500) @(negedge clk);
    rd(4'h0, d); chk("R11 busy cleared at wrap", 32'(d[28]), 32'h0);
    rd(4'h4, d); chk("R12 second write dropped", d, 32'h0001_0001);

    // R7 duty extremes
    set_ch(0, 0); wr(4'h4, 32'h0003_0000);
    set_ch(0, EN | ACT | GATE | 15);
    count_high(0, 16, hi); chk("R7 duty zero", 32'(hi), 32'd0);
    set_ch(0, 0); wr(4'h4, 32'h0002_0005);
    set_ch(0, EN | ACT | GATE | 15);
    count_high(0, 15, hi); chk("R7 duty above period", 32'(hi), 32'd15);

    // R8 polarity
    set_ch(0, 0); wr(4'h4, 32'h0003_0001);
    set_ch(0, EN | ACT | GATE | 15);
    count_high(0, 16, hi); chk("R8 active high", 32'(hi), 32'd4);
    set_ch(0, EN | GATE | 15);
    count_high(0, 16, hi); chk("R8 active low", 32'(hi), 32'd12);

    // R9 both enable and gate required
    set_ch(0, EN | ACT | 15);
    count_high(0, 16, hi); chk("R9 gate off", 32'(hi), 32'd0);
    set_ch(0, GATE | ACT | 15);
    count_high(0, 16, hi); chk("R9 enable off", 32'(hi), 32'd0);
    set_ch(0, EN | 15);
    count_high(0, 16, hi); chk("R9 R8 stopped idle high", 32'(hi), 32'd16);

    // R2 writable mask, R12 busy bits ignore writes
    ctrl_sw = 32'hFFFF_FFFF & CTRL_MASK;
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, d); chk("R2 R12 ctrl mask", d, CTRL_MASK);
    ctrl_sw = '0;
    wr(4'h0, 32'h0);
    rd(4'h0, d); chk("R2 ctrl cleared", d, 32'h0);
    @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule